// File: doc/BRIEF.md
# Boot Image Section Loader

This block turns a boot image, delivered one byte at a time over a valid/ready stream, into 32-bit memory write transactions. The image is a series of sections. Each section starts with an 8-byte header: a 32-bit byte count, then a 32-bit destination address. The payload follows the header. Both header fields are big-endian. The loader packs the payload bytes into words and writes them starting at the destination address, one word at a time. A byte count of zero ends the image. The loader then raises `done` and presents an entry address.

The write port has a valid signal and a stall input. While the port is stalled, the loader stops taking input bytes, so it never needs a buffer deeper than one word. The `gph_mode` input selects which address is reported as the entry point. With it low, the entry point is the destination of the first section. With it high, it is the destination of the last section, which suits images where execution starts at the final block loaded.

Top module: `boot_ldr_top`

## Requirements
- R1: After reset, `done` and `wr_valid` are 0 and `entry_addr` is 0. `in_ready` is 1 while `wr_stall` is 0.
- R2: A section header is 4 count bytes then 4 address bytes, each field most significant byte first. The section's words are written to the destination address (assumed 4-byte aligned), then to that address plus 4, plus 8, and so on, in stream order.
- R3: Payload bytes are packed big-endian. The first byte of a word goes to `wr_data[31:24]` with `wr_be[3]` set, and the fourth byte goes to `wr_data[7:0]` with `wr_be[0]` set. A full word has `wr_be` = 4'b1111.
- R4: When the byte count is not a multiple of 4, the last word of the section is written with only the leading byte enables set (4'b1000, 4'b1100 or 4'b1110). Its unused data bytes are zero.
- R5: After a section whose count is not a multiple of 4, the stream holds pad bytes up to the next 4-byte boundary of the payload. These bytes are consumed and produce no write.
- R6: While `wr_valid` is 1 and `wr_stall` is 1, `wr_valid`, `wr_addr`, `wr_data` and `wr_be` hold their values. A write completes in a cycle where `wr_valid` is 1 and `wr_stall` is 0.
- R7: `in_ready` is 0 in every cycle where `wr_stall` is 1.
- R8: The 4th byte of a zero count field sets `done`. `done` stays 1 until reset. After that, `in_ready` is 0, no further bytes are taken, and no write is issued.
- R9: With `done` set, `entry_addr` holds the destination of the first section when `gph_mode` is 0, and the destination of the last section when `gph_mode` is 1.
- R10: An image whose first count field is zero sets `done` with no write issued, and `entry_addr` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| gph_mode | input | 1 | 1: report the last section's destination as entry; 0: the first section's |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Loader takes the byte this cycle when `in_valid` is also 1 |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | 32 | Byte address of the word written |
| wr_data | output | 32 | Word data, first stream byte in bits 31:24 |
| wr_be | output | 4 | Byte enables, bit 3 covers bits 31:24 |
| wr_stall | input | 1 | Write port cannot accept this cycle |
| done | output | 1 | Terminator seen; sticky until reset |
| entry_addr | output | 32 | Entry address reported at completion |

## Verification
Two events can fall in the same cycle. One is the completion of a packed word. The other is either the arrival or the release of a write-port stall. In that cycle the loader must both refuse the next byte and keep the word still waiting on the port unchanged. The bench provokes this by running a periodic stall window of three cycles every seven while the payload streams in, so the window edges drift across the 4-byte word boundaries of full and partial words. The result is judged in two ways. The accepted writes must match an exact ordered list. Every stalled cycle must show the pending write unchanged and `in_ready` low.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;
  localparam int FIELD_BYTES = 4;                 // bytes per header field
  localparam int FIELD_W     = 8 * FIELD_BYTES;
  localparam int WORD_BYTES  = 4;                 // bytes per write word
  localparam int WORD_W      = 8 * WORD_BYTES;
  localparam int LANE_W      = $clog2(WORD_BYTES);

  typedef enum logic [2:0] {
    ST_COUNT,   // collecting the byte count field
    ST_DEST,    // collecting the destination field
    ST_LOAD,    // payload bytes
    ST_PAD,     // alignment padding after a short section
    ST_END      // terminator seen
  } ldr_state_e;
endpackage

// File: rtl/boot_ldr_ctrl.sv
module boot_ldr_ctrl
  import boot_ldr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gph_mode,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              wr_stall,
  output logic              in_ready,
  output logic              done,
  output logic [ADDR_W-1:0] entry_addr,
  output logic              byte_v,
  output logic [7:0]        byte_d,
  output logic [LANE_W-1:0] byte_lane,
  output logic              word_end,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int IDX_W = $clog2(FIELD_BYTES);
  localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(FIELD_BYTES - 1);
  localparam logic [LANE_W-1:0] LANE_LAST = LANE_W'(WORD_BYTES - 1);

  ldr_state_e         state_q, state_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [FIELD_W-9:0] shift_q, shift_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [ADDR_W-1:0]  off_q, off_d;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic [ADDR_W-1:0]  entry_q, entry_d;
  logic               seen_q, seen_d;

  logic               take;
  logic [FIELD_W-1:0] field_full;
  logic               field_last;
  logic               sec_last;

  assign in_ready   = !wr_stall && (state_q != ST_END);
  assign take       = in_valid && in_ready;
  assign field_full = {shift_q, in_data};
  assign field_last = (idx_q == IDX_LAST);
  assign sec_last   = (cnt_q == CNT_W'(1));

  // next-state process
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    shift_d = shift_q;
    cnt_d   = cnt_q;
    off_d   = off_q;
    base_d  = base_q;
    entry_d = entry_q;
    seen_d  = seen_q;
    unique case (state_q)
      ST_COUNT: begin
        shift_d = field_full[FIELD_W-9:0];
        idx_d   = idx_q + 1'b1;
        if (field_last) begin
          if (field_full == '0) state_d = ST_END;
          else begin
            cnt_d   = field_full[CNT_W-1:0];
            state_d = ST_DEST;
          end
        end
      end
      ST_DEST: begin
        shift_d = field_full[FIELD_W-9:0];
        idx_d   = idx_q + 1'b1;
        if (field_last) begin
          base_d  = field_full[ADDR_W-1:0];
          off_d   = '0;
          seen_d  = 1'b1;
          if (gph_mode || !seen_q) entry_d = field_full[ADDR_W-1:0];
          state_d = ST_LOAD;
        end
      end
      ST_LOAD: begin
        off_d = off_q + 1'b1;
        cnt_d = cnt_q - 1'b1;
        if (sec_last)
          state_d = (off_q[LANE_W-1:0] == LANE_LAST) ? ST_COUNT : ST_PAD;
      end
      ST_PAD: begin
        off_d = off_q + 1'b1;
        if (off_q[LANE_W-1:0] == LANE_LAST) state_d = ST_COUNT;
      end
      default: ;
    endcase
  end

  // register process, enabled only by an accepted byte
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_COUNT;
      idx_q   <= '0;
      shift_q <= '0;
      cnt_q   <= '0;
      off_q   <= '0;
      base_q  <= '0;
      entry_q <= '0;
      seen_q  <= 1'b0;
    end else if (take) begin
      state_q <= state_d;
      idx_q   <= idx_d;
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
      off_q   <= off_d;
      base_q  <= base_d;
      entry_q <= entry_d;
      seen_q  <= seen_d;
    end
  end

  assign done       = (state_q == ST_END);
  assign entry_addr = entry_q;
  assign byte_v     = take && (state_q == ST_LOAD);
  assign byte_d     = in_data;
  assign byte_lane  = off_q[LANE_W-1:0];
  assign word_end   = byte_v && ((off_q[LANE_W-1:0] == LANE_LAST) || sec_last);
  assign word_addr  = base_q + {off_q[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};

  // R8: completion is sticky
  a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

// File: rtl/boot_ldr_pack.sv
module boot_ldr_pack
  import boot_ldr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_v,
  input  logic [7:0]        byte_d,
  input  logic [LANE_W-1:0] byte_lane,
  input  logic              word_end,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic              wr_stall,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [WORD_BYTES-1:0] wr_be
);
  logic [WORD_W-1:0]     acc_q, acc_d, acc_ins;
  logic [WORD_BYTES-1:0] be_q, be_d, be_ins;
  logic                  vld_q, vld_d;
  logic [ADDR_W-1:0]     addr_q, addr_d;
  logic [WORD_W-1:0]     data_q, data_d;
  logic [WORD_BYTES-1:0] obe_q, obe_d;
  logic                  acc_en, out_en;

  // lane 0 is the lowest-addressed byte and lands in the top bits
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    localparam int HI = WORD_W - 1 - 8 * g;
    logic hit;
    assign hit = byte_v && (byte_lane == LANE_W'(g));
    assign acc_ins[HI -: 8] = hit ? byte_d : acc_q[HI -: 8];
    assign be_ins[WORD_BYTES-1-g] = hit | be_q[WORD_BYTES-1-g];
  end

  assign acc_en = byte_v;
  assign out_en = word_end || !wr_stall;

  always_comb begin
    acc_d  = word_end ? '0 : acc_ins;
    be_d   = word_end ? '0 : be_ins;
    vld_d  = word_end;
    addr_d = word_end ? word_addr : addr_q;
    data_d = word_end ? acc_ins   : data_q;
    obe_d  = word_end ? be_ins    : obe_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      be_q  <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
      be_q  <= be_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      obe_q  <= '0;
    end else if (out_en) begin
      vld_q  <= vld_d;
      addr_q <= addr_d;
      data_q <= data_d;
      obe_q  <= obe_d;
    end
  end

  assign wr_valid = vld_q;
  assign wr_addr  = addr_q;
  assign wr_data  = data_q;
  assign wr_be    = obe_q;

  // R7: no payload byte arrives while the port is stalled
  a_r7_no_byte_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    byte_v |-> !wr_stall);

  // R6: a stalled write is held unchanged
  a_r6_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_stall) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be)));
endmodule

// File: rtl/boot_ldr_top.sv
module boot_ldr_top
  import boot_ldr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gph_mode,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic [WORD_BYTES-1:0] wr_be,
  input  logic              wr_stall,
  output logic              done,
  output logic [ADDR_W-1:0] entry_addr
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              byte_v;
  logic [7:0]        byte_d;
  logic [LANE_W-1:0] byte_lane;
  logic              word_end;
  logic [ADDR_W-1:0] word_addr;

  boot_ldr_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .gph_mode   (gph_mode),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .wr_stall   (wr_stall),
    .in_ready   (in_ready),
    .done       (done),
    .entry_addr (entry_addr),
    .byte_v     (byte_v),
    .byte_d     (byte_d),
    .byte_lane  (byte_lane),
    .word_end   (word_end),
    .word_addr  (word_addr)
  );

  boot_ldr_pack #(.ADDR_W(ADDR_W)) i_pack (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .byte_v    (byte_v),
    .byte_d    (byte_d),
    .byte_lane (byte_lane),
    .word_end  (word_end),
    .word_addr (word_addr),
    .wr_stall  (wr_stall),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_be     (wr_be)
  );

  // R4: enables are a leading run starting at the top byte
  a_r4_be_leading: assert property (@(posedge clk) disable iff (!rst_int_n)
    wr_valid |-> (wr_be == 4'b1000 || wr_be == 4'b1100 || wr_be == 4'b1110 || wr_be == 4'b1111));

  // R8: nothing is written once the terminator has been seen
  a_r8_no_write_after_done: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> !wr_valid);
endmodule

// File: tb/test_boot_ldr_top.sv
module test_boot_ldr_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        gph_mode;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready;
  logic        wr_valid;
  logic [31:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;
  logic        wr_stall;
  logic        done;
  logic [31:0] entry_addr;

  int n_run  = 0;
  int n_fail = 0;

  boot_ldr_top i_boot_ldr_top (
    .clk(clk), .rst_n(rst_n), .gph_mode(gph_mode),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .wr_stall(wr_stall), .done(done), .entry_addr(entry_addr)
  );

  always #10 clk = ~clk;   // 20 ns period, 50 MHz

  // stream: three sections, terminator, two stray bytes; then a bare terminator
  localparam logic [7:0] IMG [0:55] = '{
    8'h00,8'h00,8'h00,8'h08, 8'h00,8'h00,8'h10,8'h00,
    8'h11,8'h22,8'h33,8'h44, 8'h55,8'h66,8'h77,8'h88,
    8'h00,8'h00,8'h00,8'h05, 8'h00,8'h00,8'h20,8'h00,
    8'hA1,8'hA2,8'hA3,8'hA4, 8'hA5,8'hEE,8'hEE,8'hEE,
    8'h00,8'h00,8'h00,8'h02, 8'h00,8'h00,8'h30,8'h10,
    8'hB1,8'hB2,8'hEE,8'hEE,
    8'h00,8'h00,8'h00,8'h00, 8'hDE,8'hAD,
    8'h00,8'h00,8'h00,8'h00, 8'hDE,8'hAD
  };
  // expected writes: {addr, data, be}
  localparam logic [67:0] EXP [0:4] = '{
    {32'h0000_1000, 32'h1122_3344, 4'hF},
    {32'h0000_1004, 32'h5566_7788, 4'hF},
    {32'h0000_2000, 32'hA1A2_A3A4, 4'hF},
    {32'h0000_2004, 32'hA500_0000, 4'h8},
    {32'h0000_3010, 32'hB1B2_0000, 4'hC}
  };

  int   widx;
  int   exp_n;
  logic mon_on = 1'b0;
  logic stall_en = 1'b0;

  task automatic chk(input logic ok, input string req, input logic [67:0] act, input logic [67:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // stall pattern: three stalled cycles out of seven
  initial begin
    int cyc = 0;
    wr_stall = 1'b0;
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      wr_stall = stall_en && ((cyc % 7) >= 2) && ((cyc % 7) <= 4);
    end
  end

  // write monitor
  initial begin
    logic        pend = 1'b0;
    logic [67:0] held = '0;
    forever begin
      @(negedge clk);
      if (mon_on) begin
        if (pend) // R6 hold while stalled
          chk(wr_valid && {wr_addr, wr_data, wr_be} == held, "R6 held write",
              {wr_addr, wr_data, wr_be}, held);
        if (wr_stall) // R7
          chk(!in_ready, "R7 ready during stall", {67'd0, in_ready}, 68'd0);
        pend = wr_valid && wr_stall;
        held = {wr_addr, wr_data, wr_be};
        if (wr_valid && !wr_stall) begin
          if (widx < exp_n)
            chk({wr_addr, wr_data, wr_be} == EXP[widx],
                (EXP[widx][3:0] == 4'hF) ? "R2 R3 full word" : "R4 partial word",
                {wr_addr, wr_data, wr_be}, EXP[widx]);
          else
            chk(1'b0, "R8 R5 unexpected write", {wr_addr, wr_data, wr_be}, 68'd0);
          widx++;
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog: run did not complete, actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic do_reset(input logic mode);
    mon_on   = 1'b0;
    in_valid = 1'b0;
    in_data  = 8'h00;
    gph_mode = mode;
    rst_n    = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    widx   = 0;
    mon_on = 1'b1;
  endtask

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // offer stray bytes that must not be taken
  task automatic offer_junk(input int first, input int last);
    for (int i = first; i <= last; i++) begin
      in_valid = 1'b1;
      in_data  = IMG[i];
      repeat (4) @(negedge clk);
      chk(!in_ready, "R8 stray byte refused", {67'd0, in_ready}, 68'd0);
    end
    in_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; gph_mode = 1'b0; in_valid = 1'b0; in_data = 8'h00;
    exp_n = 5;

    // R1 reset state
    do_reset(1'b0);
    chk(in_ready && !wr_valid && !done && entry_addr == 32'd0, "R1 reset state",
        {64'd0, in_ready, wr_valid, done, |entry_addr}, {64'd0, 4'b1000});

    // run 1: first-section entry, periodic stall (R2 R3 R4 R5 R6 R7)
    stall_en = 1'b1;
    for (int i = 0; i < 48; i++) send(IMG[i]);
    offer_junk(48, 49);
    repeat (4) @(negedge clk);
    chk(widx == 5, "R2 R5 write count", 68'(widx), 68'd5);
    chk(done, "R8 done set", {67'd0, done}, 68'd1);
    chk(entry_addr == 32'h1000, "R9 entry first section", {36'd0, entry_addr}, 68'h1000);
    repeat (10) @(negedge clk);
    chk(done && !wr_valid, "R8 done sticky", {66'd0, done, wr_valid}, 68'b10);

    // run 2: last-section entry, no stall
    stall_en = 1'b0;
    do_reset(1'b1);
    for (int i = 0; i < 48; i++) send(IMG[i]);
    offer_junk(48, 49);
    chk(widx == 5, "R2 write count without stall", 68'(widx), 68'd5);
    chk(entry_addr == 32'h3010, "R9 entry last section", {36'd0, entry_addr}, 68'h3010);

    // run 3: bare terminator (R10)
    stall_en = 1'b1;
    exp_n = 0;
    do_reset(1'b1);
    for (int i = 50; i < 54; i++) send(IMG[i]);
    offer_junk(54, 55);
    chk(done, "R10 done on empty image", {67'd0, done}, 68'd1);
    chk(widx == 0, "R10 no write", 68'(widx), 68'd0);
    chk(entry_addr == 32'd0, "R10 entry zero", {36'd0, entry_addr}, 68'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule